// File: doc/BRIEF.md
# Auxiliary-channel request bridge to register bus and I2C

This block executes byte-oriented requests arriving from an auxiliary display channel. A request carries a 4-bit command, an address, a length of zero to sixteen bytes and a sixteen-byte data buffer. Native requests are carried out one byte at a time on a simple register bus, walking through consecutive addresses. I2C requests are carried out through a byte-level I2C master command port. That port offers start-for-read, start-for-write, send-byte, receive-byte and stop commands, and it returns an acknowledge bit for each one.

An I2C request may carry a middle-of-transaction flag. When the flag is set, the bridge leaves the I2C transaction open after the request ends. A later flagged request with the same command and the same 7-bit address continues that transaction without a new start. A flagged request with a different command or address first stops the open transaction and then starts a new one. Every request ends with a 2-bit reply code and, for reads, the received bytes. Request and reply each use a valid/ready handshake, and the next request is accepted only after the reply has been taken.

Top module: `aux_i2c_bridge`

## Requirements
- R1: Command encoding: bit 3 set means I2C and clear means native, bit 2 is the middle-of-transaction flag, and bits 1:0 are 00 for write and 01 for read. Reply codes are 00 ACK, 01 NACK and 10 I2C-NACK. `req_ready` is high only while no request is in progress and no reply is pending. `rsp_valid` with `rsp_code` holds until `rsp_ready` is seen.
- R2: A native request with length N makes N register accesses, one at a time, to the addresses A, A+1, ..., A+N-1. Writes send byte i of `req_data` (bits 8i+7:8i). Reads place each returned byte at byte i of `rsp_data`. A fully successful request replies ACK, and this includes N = 0, which makes no access.
- R3: If a native access returns `reg_err`, no further access is made and the reply is NACK.
- R4: I2C master op codes are 0 start-write, 1 start-read, 2 send, 3 receive and 4 stop, and a start carries `req_addr[6:0]`. A request without the flag first issues a stop if `i2c_busy` is high, then issues a start.
- R5: A start that is not acknowledged ends the request at once with I2C-NACK. No data byte is moved and no stop is issued.
- R6: A plain I2C read receives exactly N bytes, then issues a stop and replies ACK.
- R7: A plain I2C write sends bytes in order and stops sending at the first byte that is not acknowledged, replying I2C-NACK. Otherwise it replies ACK. A stop is issued in both cases.
- R8: A flagged request issues a start if `i2c_busy` is low. If `i2c_busy` is high and the command or address differs from the saved pair, it issues a stop and then a start. If both match, it moves data with no start.
- R9: After an acknowledged flagged start, the command and address are saved. A flagged request issues no stop at its end unless R10 applies.
- R10: In a flagged write, a byte that is not acknowledged causes a stop and an I2C-NACK reply.
- R11: A command outside {0000, 0001, 1000, 1001, 1100, 1101}, or a length above 16, replies NACK with no register or I2C activity.
- R12: `reg_valid` with its address, direction and data, and `i2c_valid` with its op, address and data, stay asserted and unchanged until the matching done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_cmd | input | 4 | Command (R1 encoding) |
| req_addr | input | ADDR_W | Register address, or I2C address in bits 6:0 |
| req_len | input | LEN_W | Byte count, 0 to MAX_LEN |
| req_data | input | 8*MAX_LEN | Write bytes, byte i in bits 8i+7:8i |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Reply taken |
| rsp_code | output | 2 | Reply code |
| rsp_data | output | 8*MAX_LEN | Read bytes, byte i in bits 8i+7:8i |
| reg_valid | output | 1 | Register access requested |
| reg_write | output | 1 | 1 write, 0 read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 8 | Write byte |
| reg_done | input | 1 | Access completed this cycle |
| reg_err | input | 1 | Access failed (with reg_done) |
| reg_rdata | input | 8 | Read byte (with reg_done) |
| i2c_valid | output | 1 | I2C op requested |
| i2c_op | output | 3 | I2C op code (R4) |
| i2c_addr | output | 7 | Target address for starts |
| i2c_wdata | output | 8 | Byte to send |
| i2c_done | input | 1 | Op completed this cycle |
| i2c_ack | input | 1 | Op acknowledged (with i2c_done) |
| i2c_rdata | input | 8 | Received byte (with i2c_done) |
| i2c_busy | input | 1 | An I2C transaction is open |

## Verification
The state most likely to go wrong is the saved command and address pair used for flagged requests. If that pair is corrupted, the very next flagged request shows a stray stop and start, or a missing one, at the first op it issues. If the byte index or the length compare is wrong, an op appears at an unexpected address or an extra receive or send appears before the reply. The bench therefore compares every completed register and I2C op against its expected sequence in the cycle it completes. The reply code and the read bytes are checked when the reply appears.

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge #(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3:0]           req_cmd,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [8*MAX_LEN-1:0] req_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_code,
  output logic [8*MAX_LEN-1:0] rsp_data,
  output logic                 reg_valid,
  output logic                 reg_write,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [7:0]           reg_wdata,
  input  logic                 reg_done,
  input  logic                 reg_err,
  input  logic [7:0]           reg_rdata,
  output logic                 i2c_valid,
  output logic [2:0]           i2c_op,
  output logic [6:0]           i2c_addr,
  output logic [7:0]           i2c_wdata,
  input  logic                 i2c_done,
  input  logic                 i2c_ack,
  input  logic [7:0]           i2c_rdata,
  input  logic                 i2c_busy
);
  localparam int IW = $clog2(MAX_LEN);
  localparam logic [1:0] RC_ACK = 2'd0, RC_NACK = 2'd1, RC_I2CNACK = 2'd2;
  localparam logic [2:0] OP_SW = 3'd0, OP_SR = 3'd1, OP_TX = 3'd2, OP_RX = 3'd3, OP_STOP = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_NAT, S_PRESTOP, S_START, S_DATA, S_POSTSTOP, S_RESP} state_t;

  state_t            state;
  logic [3:0]        cmd_q, last_cmd;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, idx;
  logic [1:0]        code_q;
  logic [6:0]        last_addr;
  logic [7:0]        buf_q [MAX_LEN];

  wire in_ok   = (req_cmd[1] == 1'b0) && (req_cmd[3] || !req_cmd[2]) && (req_len <= LEN_W'(MAX_LEN));
  wire in_same = (req_addr[6:0] == last_addr) && (req_cmd == last_cmd);
  wire is_rd   = cmd_q[0];
  wire is_mot  = cmd_q[2];
  wire at_last = (idx == len_q - LEN_W'(1));
  wire [IW-1:0] bi = idx[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      idx       <= '0;
      code_q    <= RC_ACK;
      last_cmd  <= '0;
      last_addr <= '0;
      for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cmd_q  <= req_cmd;
          addr_q <= req_addr;
          len_q  <= req_len;
          idx    <= '0;
          code_q <= RC_ACK;
          for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= req_data[8*i +: 8];
          if (!in_ok) begin
            code_q <= RC_NACK;
            state  <= S_RESP;
          end else if (!req_cmd[3])
            state <= (req_len == '0) ? S_RESP : S_NAT;
          else if (!req_cmd[2] || !i2c_busy)
            state <= i2c_busy ? S_PRESTOP : S_START;
          else if (!in_same)
            state <= S_PRESTOP;
          else
            state <= (req_len == '0) ? S_RESP : S_DATA;
        end
        S_NAT: if (reg_done) begin
          if (reg_err) begin
            code_q <= RC_NACK;
            state  <= S_RESP;
          end else begin
            if (is_rd) buf_q[bi] <= reg_rdata;
            if (at_last) state <= S_RESP;
            else idx <= idx + LEN_W'(1);
          end
        end
        S_PRESTOP: if (i2c_done) state <= S_START;
        S_START: if (i2c_done) begin
          if (!i2c_ack) begin
            code_q <= RC_I2CNACK;
            state  <= S_RESP;
          end else begin
            if (is_mot) begin
              last_cmd  <= cmd_q;
              last_addr <= addr_q[6:0];
            end
            if (len_q == '0) state <= is_mot ? S_RESP : S_POSTSTOP;
            else state <= S_DATA;
          end
        end
        S_DATA: if (i2c_done) begin
          if (!is_rd && !i2c_ack) begin
            code_q <= RC_I2CNACK;
            state  <= S_POSTSTOP;
          end else begin
            if (is_rd) buf_q[bi] <= i2c_rdata;
            if (at_last) state <= is_mot ? S_RESP : S_POSTSTOP;
            else idx <= idx + LEN_W'(1);
          end
        end
        S_POSTSTOP: if (i2c_done) state <= S_RESP;
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_code  = code_q;
  for (genvar g = 0; g < MAX_LEN; g++) begin : g_rsp
    assign rsp_data[8*g +: 8] = buf_q[g];
  end

  assign reg_valid = (state == S_NAT);
  assign reg_write = !is_rd;
  assign reg_addr  = addr_q + ADDR_W'(idx);
  assign reg_wdata = buf_q[bi];

  assign i2c_valid = (state == S_PRESTOP) || (state == S_START) || (state == S_DATA) || (state == S_POSTSTOP);
  assign i2c_addr  = addr_q[6:0];
  assign i2c_wdata = buf_q[bi];
  always_comb begin
    case (state)
      S_START: i2c_op = is_rd ? OP_SR : OP_SW;
      S_DATA:  i2c_op = is_rd ? OP_RX : OP_TX;
      default: i2c_op = OP_STOP;
    endcase
  end

  assert_reg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_done |=> reg_valid && $stable(reg_addr) && $stable(reg_write) && $stable(reg_wdata));
  assert_i2c_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_valid && !i2c_done |=> i2c_valid && $stable(i2c_op) && $stable(i2c_addr) && $stable(i2c_wdata));
  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code));
  assert_one_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_bad_cmd_nack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !in_ok |=> rsp_valid && rsp_code == RC_NACK);
  assert_nat_err_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_done && reg_err |=> rsp_valid && rsp_code == RC_NACK);
  assert_start_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_valid && i2c_done && !i2c_ack && (i2c_op == OP_SW || i2c_op == OP_SR) |=> rsp_valid && rsp_code == RC_I2CNACK);
  assert_tx_nack_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_valid && i2c_done && !i2c_ack && i2c_op == OP_TX |=> i2c_valid && i2c_op == OP_STOP);
endmodule

// File: tb/aux_i2c_bridge_tb.sv
module aux_i2c_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int ML = 16;
  localparam int LW = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 0;
  logic [3:0] req_cmd = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [8*ML-1:0] req_data = 0, rsp_data;
  logic [1:0] rsp_code;
  logic reg_valid, reg_write, reg_done = 0, reg_err = 0;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata = 0;
  logic i2c_valid, i2c_done = 0, i2c_ack = 0, i2c_busy;
  logic [2:0] i2c_op;
  logic [6:0] i2c_addr;
  logic [7:0] i2c_wdata, i2c_rdata = 0;

  aux_i2c_bridge #(.ADDR_W(AW), .MAX_LEN(ML)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  longint exp_q[$];
  int ai = 0;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic longint mk(input int t, input int a, input int d);
    return (longint'(t) << 32) | (longint'(a & 32'hFFFFF) << 8) | longint'(d & 8'hFF);
  endfunction

  task automatic log_op(input longint v);
    if (ai < exp_q.size()) chk(v == exp_q[ai], cur_req, "op", v, exp_q[ai]);
    else chk(0, cur_req, "unexpected op", v, 0);
    ai++;
  endtask

  // register device
  logic [7:0] mem [64];
  int err_addr = -1, rlat = 0, rc = 0;
  logic [AW:0] r_hold;
  always @(negedge clk) begin
    if (reg_done) begin reg_done = 0; reg_err = 0; rc = 0; end
    else if (reg_valid) begin
      if (rc == 0) r_hold = {reg_write, reg_addr};
      if (rc >= rlat) begin
        if (rc > 0) chk(r_hold == {reg_write, reg_addr}, "R12", "reg hold", longint'({reg_write, reg_addr}), longint'(r_hold));
        reg_done = 1; rc = 0;
        reg_err = (int'(reg_addr) == err_addr);
        if (reg_write) begin
          log_op(mk(8, int'(reg_addr), int'(reg_wdata)));
          if (!reg_err) mem[reg_addr[5:0]] = reg_wdata;
        end else begin
          reg_rdata = reg_err ? 8'h00 : mem[reg_addr[5:0]];
          log_op(mk(9, int'(reg_addr), int'(reg_rdata)));
        end
      end else rc++;
    end
  end

  // I2C device
  logic dev_busy = 0;
  logic [7:0] dev_rx = 8'hA0;
  int ilat = 0, ic = 0;
  logic [17:0] i_hold;
  assign i2c_busy = dev_busy;
  function automatic bit present(input logic [6:0] a);
    return a == 7'h50 || a == 7'h21;
  endfunction
  always @(negedge clk) begin
    if (i2c_done) begin i2c_done = 0; ic = 0; end
    else if (i2c_valid) begin
      if (ic == 0) i_hold = {i2c_op, i2c_addr, i2c_wdata};
      if (ic >= ilat) begin
        if (ic > 0) chk(i_hold == {i2c_op, i2c_addr, i2c_wdata}, "R12", "i2c hold", longint'({i2c_op, i2c_addr, i2c_wdata}), longint'(i_hold));
        i2c_done = 1; ic = 0;
        case (i2c_op)
          3'd0, 3'd1: begin i2c_ack = present(i2c_addr); dev_busy = i2c_ack; log_op(mk(int'(i2c_op), int'(i2c_addr), 0)); end
          3'd2: begin i2c_ack = (i2c_wdata != 8'hFF); log_op(mk(2, 0, int'(i2c_wdata))); end
          3'd3: begin i2c_ack = 1; i2c_rdata = dev_rx; dev_rx = dev_rx + 1; log_op(mk(3, 0, int'(i2c_rdata))); end
          default: begin i2c_ack = 1; dev_busy = 0; log_op(mk(4, 0, 0)); end
        endcase
      end else ic++;
    end
  end

  // reference model state
  logic [7:0] m_mem [64];
  bit m_busy = 0;
  logic [6:0] m_last_addr = 0;
  logic [3:0] m_last_cmd = 0;
  logic [7:0] m_rx = 8'hA0;

  task automatic run(input string rq, input logic [3:0] cmd, input int addr, input int len, input logic [8*ML-1:0] data);
    logic [1:0] ecode;
    logic [7:0] edata [ML];
    bit ok, rd, mot, need_start, started;
    logic [6:0] a7;
    int w;
    cur_req = rq;
    exp_q.delete(); ai = 0;
    for (int i = 0; i < ML; i++) edata[i] = 0;
    ok = (cmd[1] == 0) && (cmd[3] || !cmd[2]) && (len <= ML);
    rd = cmd[0]; mot = cmd[2]; a7 = addr[6:0];
    if (!ok) ecode = 2'd1;
    else if (!cmd[3]) begin
      ecode = 2'd0;
      for (int i = 0; i < len; i++) begin
        int a = addr + i;
        if (rd) begin
          edata[i] = (a == err_addr) ? 8'h00 : m_mem[a[5:0]];
          exp_q.push_back(mk(9, a, int'(edata[i])));
        end else begin
          exp_q.push_back(mk(8, a, int'(data[8*i +: 8])));
          if (a != err_addr) m_mem[a[5:0]] = data[8*i +: 8];
        end
        if (a == err_addr) begin ecode = 2'd1; break; end
      end
    end else begin
      need_start = 1;
      if (!mot) begin
        if (m_busy) begin exp_q.push_back(mk(4, 0, 0)); m_busy = 0; end
      end else if (m_busy) begin
        if (a7 != m_last_addr || cmd != m_last_cmd) begin exp_q.push_back(mk(4, 0, 0)); m_busy = 0; end
        else need_start = 0;
      end
      started = 1;
      ecode = 2'd0;
      if (need_start) begin
        exp_q.push_back(mk(rd ? 1 : 0, int'(a7), 0));
        if (!present(a7)) begin ecode = 2'd2; started = 0; m_busy = 0; end
        else begin m_busy = 1; if (mot) begin m_last_addr = a7; m_last_cmd = cmd; end end
      end
      if (started) begin
        for (int i = 0; i < len; i++) begin
          if (rd) begin edata[i] = m_rx; exp_q.push_back(mk(3, 0, int'(m_rx))); m_rx = m_rx + 1; end
          else begin
            exp_q.push_back(mk(2, 0, int'(data[8*i +: 8])));
            if (data[8*i +: 8] == 8'hFF) begin ecode = 2'd2; break; end
          end
        end
        if (!mot || ecode == 2'd2) begin exp_q.push_back(mk(4, 0, 0)); m_busy = 0; end
      end
    end
    // drive
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready before request", longint'(req_ready), 1);
    req_cmd = cmd; req_addr = AW'(addr); req_len = LW'(len); req_data = data; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    w = 0;
    while (!rsp_valid && w < 400) begin
      chk(req_ready == 0, "R1", "ready while busy", longint'(req_ready), 0);
      @(negedge clk); w++;
    end
    chk(rsp_valid == 1, rq, "reply seen", longint'(rsp_valid), 1);
    chk(rsp_code == ecode, rq, "reply code", longint'(rsp_code), longint'(ecode));
    chk(ai == exp_q.size(), rq, "op count", longint'(ai), longint'(exp_q.size()));
    if (ok && rd && ecode == 2'd0)
      for (int i = 0; i < len; i++)
        chk(rsp_data[8*i +: 8] == edata[i], rq, "read byte", longint'(rsp_data[8*i +: 8]), longint'(edata[i]));
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_code == ecode && req_ready == 0, "R1", "reply held", longint'(rsp_code), longint'(ecode));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(rsp_valid == 0 && req_ready == 1, "R1", "reply taken", longint'(rsp_valid), 0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 8'(i * 3); m_mem[i] = 8'(i * 3); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !reg_valid && !i2c_valid, "R1", "reset state",
        longint'({req_ready, rsp_valid, reg_valid, i2c_valid}), 4'b1000);
    // native
    run("R2", 4'b0000, 16, 4, 128'h44332211);
    rlat = 2;
    run("R2", 4'b0001, 14, 6, 0);
    rlat = 1;
    run("R2", 4'b0001, 0, 16, 0);
    run("R2", 4'b0000, 8, 0, 0);
    err_addr = 18;
    run("R3", 4'b0000, 16, 4, 128'h99887766);
    rlat = 0;
    run("R3", 4'b0001, 17, 3, 0);
    err_addr = -1;
    // plain I2C
    run("R7", 4'b1000, 16'h50, 3, 128'h030201);
    ilat = 2;
    run("R6", 4'b1001, 16'h50, 5, 0);
    run("R5", 4'b1000, 16'h33, 3, 128'h030201);
    ilat = 1;
    run("R7", 4'b1000, 16'h21, 4, 128'h04FF0201);
    run("R6", 4'b1001, 16'h21, 16, 0);
    // flagged
    ilat = 0;
    run("R8", 4'b1100, 16'h50, 2, 128'h2211);
    run("R9", 4'b1100, 16'h50, 2, 128'h4433);
    run("R11", 4'b0010, 16'h50, 2, 0);
    run("R11", 4'b0100, 16'h50, 2, 0);
    run("R11", 4'b1100, 16'h50, 17, 0);
    run("R9", 4'b1100, 16'h50, 1, 128'h55);
    run("R8", 4'b1101, 16'h50, 3, 0);
    run("R9", 4'b1101, 16'h50, 2, 0);
    run("R8", 4'b1101, 16'h21, 2, 0);
    run("R4", 4'b1001, 16'h21, 2, 0);
    run("R8", 4'b1100, 16'h21, 2, 128'h7766);
    run("R10", 4'b1100, 16'h21, 3, 128'h88FF66);
    run("R5", 4'b1101, 16'h33, 2, 0);
    run("R9", 4'b1100, 16'h50, 0, 0);
    run("R4", 4'b1000, 16'h50, 1, 128'h12);
    run("R11", 4'b1110, 16'h50, 1, 0);
    finish_run();
  end
endmodule